// File: doc/BRIEF.md
# Spare-Wire Link Repair Receiver

This block sits at the receiving end of one direction of a point-to-point mesh link. Each transfer arrives on 76 functional wires, made up of 64 data, 8 check and 4 control wires, plus `NSPARE` spare wires. On every hop the block decodes a single-error-correcting, double-error-detecting code. The code covers the data and control bits together. The block corrects any single failed wire and reports which wire it was.

A wire that fails only once is treated as a transient upset and is simply corrected. A data wire that is located as faulty on `KHITS` consecutive transfers is declared permanently broken. The block then steers that data lane onto the lowest-numbered free spare wire. It publishes the new steering map in the same cycle, so the transmitter can start driving the lane's value on that spare. A fault located on a check or control wire cannot be spared. In that case, and when no spare is left, a sticky failure flag is raised.

The spare count is a per-instance parameter, so links with more exposure can be built with more spares than others.

Top module: `spare_link_rx`

## Requirements
- R1: After reset, `out_valid`, `out_corrected`, `out_uncorrectable`, `link_failed` and every bit of `steer_active` are 0, and `spares_left` equals `NSPARE`.
- R2: Each accepted transfer (`in_valid`=1) produces exactly one output one clock later with `out_valid`=1. For an error-free word, the output carries the data and control bits unchanged and both error flags are 0. Pin layout: pins 0..63 are data, pins 64..70 are Hamming bits h0..h6, pin 71 is overall parity, pins 72..75 are control, and spare s is pin 76+s. Code layout: the 68 protected bits (data 0..63, then control 0..3) occupy, in order, the codeword positions 3, 5, 6, 7, 9, ... that are not powers of two. Hamming bit hp is the XOR of the protected bits whose position has bit p set. Overall parity is the XOR of all 68 protected bits and h0..h6.
- R3: When exactly one of the 76 functional wires is inverted, the output data and control are the original values and `out_corrected` is 1 for that transfer.
- R4: When two wires are inverted, `out_uncorrectable` is 1 and `out_corrected` is 0. Such a transfer leaves the consecutive-hit history untouched.
- R5: A data lane located as faulty on `KHITS` consecutive transfers is declared permanent. It is assigned the lowest-indexed free spare: `steer_active[s]`=1 and `steer_lane[6s+5:6s]` holds the lane number. `spares_left` drops by one. All of this is visible together with that transfer's output.
- R6: The hit count restarts when an error-free transfer arrives or a different wire is located. Cycles without `in_valid` do not affect it.
- R7: From the next transfer after a declaration, the remapped lane is read from its spare pin. Its original pin is ignored, and a single fault on that spare pin is corrected and attributed to the lane.
- R8: If a lane that is already on a spare is declared again, it moves to the next free spare. The previous spare's `steer_active` bit clears and that spare is never reused.
- R9: A declaration with no free spare sets `link_failed`. `link_failed` stays 1 until reset, and the steering map no longer changes.
- R10: A single fault located on a check or control wire is corrected and sets `link_failed` with that transfer's output, without consuming a spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transfer present on `in_wires` this cycle |
| in_wires | input | 76+NSPARE | Functional and spare link wires |
| out_valid | output | 1 | Corrected transfer present |
| out_data | output | 64 | Corrected data |
| out_ctrl | output | 4 | Corrected control bits |
| out_corrected | output | 1 | Single wire error was corrected |
| out_uncorrectable | output | 1 | Double error detected; data not trusted |
| steer_active | output | NSPARE | Spare s currently carries a data lane |
| steer_lane | output | 6*NSPARE | Lane number carried by each spare |
| spares_left | output | clog2(NSPARE+1) | Spares never yet allocated |
| link_failed | output | 1 | Sticky: link cannot be repaired |

## Verification
The properties assume that reset is held across at least one clock edge, and that `in_wires` carries known values whenever `in_valid` is high. Under these conditions the steering map can change only on an edge that accepted a transfer. The stimulus always drives a full codeword computed from the stated layout. It places each remapped lane's value on its spare pin and then inverts chosen pins on purpose. It also returns `in_valid` low between scenarios, so idle cycles are mixed in with the hit sequences.

// File: rtl/link_repair_pkg.sv
package link_repair_pkg;

    localparam int DATA_W    = 64;
    localparam int CTRL_W    = 4;
    localparam int HAM_W     = 7;
    localparam int CHK_W     = HAM_W + 1;
    localparam int INFO_W    = DATA_W + CTRL_W;
    localparam int FUNC_W    = DATA_W + CHK_W + CTRL_W;
    localparam int LOC_W     = 7;
    localparam int LANE_W    = 6;
    localparam int CHK_BASE  = DATA_W;
    localparam int OVP_WIRE  = DATA_W + HAM_W;
    localparam int CTRL_BASE = DATA_W + CHK_W;

    typedef enum logic [1:0] {
        ECC_CLEAN = 2'd0,
        ECC_FIX   = 2'd1,
        ECC_BAD   = 2'd2
    } ecc_kind_e;

    typedef enum logic [1:0] {
        SP_FREE    = 2'd0,
        SP_ACTIVE  = 2'd1,
        SP_RETIRED = 2'd2
    } spare_st_e;

    typedef struct packed {
        logic                vld;
        logic [DATA_W-1:0]   data;
        logic [CTRL_W-1:0]   ctrl;
        logic                fix;
        logic                bad;
    } out_stage_t;

    // Codeword position of each protected bit: the non-power-of-two slots in order.
    function automatic logic [INFO_W-1:0][LOC_W-1:0] pos_table();
        logic [INFO_W-1:0][LOC_W-1:0] t;
        int n;
        t = '0;
        n = 0;
        for (int q = 3; q < 128; q++) begin
            if (((q & (q - 1)) != 0) && (n < INFO_W)) begin
                t[n] = LOC_W'(q);
                n++;
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/lane_steer.sv
module lane_steer
    import link_repair_pkg::*;
#(
    parameter  int NSPARE = 2,
    localparam int NW     = FUNC_W + NSPARE
) (
    input  logic [NW-1:0]            wires,
    input  logic [NSPARE-1:0]        act,
    input  logic [NSPARE*LANE_W-1:0] lane,
    output logic [DATA_W-1:0]        data
);

    for (genvar j = 0; j < DATA_W; j++) begin : g_lane
        logic pick;
        always_comb begin
            pick = wires[j];
            for (int s = 0; s < NSPARE; s++) begin
                if (act[s] && (lane[s*LANE_W +: LANE_W] == LANE_W'(j))) begin
                    pick = wires[FUNC_W + s];
                end
            end
        end
        assign data[j] = pick;
    end

endmodule

// File: rtl/secded_locate.sv
module secded_locate
    import link_repair_pkg::*;
(
    input  logic [INFO_W-1:0] info,
    input  logic [CHK_W-1:0]  chk,
    output logic [INFO_W-1:0] fixed,
    output ecc_kind_e         kind,
    output logic [LOC_W-1:0]  loc
);

    localparam logic [INFO_W-1:0][LOC_W-1:0] POS = pos_table();

    logic [HAM_W-1:0] syn;
    logic             par;
    logic             hit;

    always_comb begin
        syn = chk[HAM_W-1:0];
        for (int i = 0; i < INFO_W; i++) begin
            for (int p = 0; p < HAM_W; p++) begin
                if (POS[i][p]) syn[p] = syn[p] ^ info[i];
            end
        end
        par = (^info) ^ (^chk);
    end

    always_comb begin
        fixed = info;
        kind  = ECC_CLEAN;
        loc   = '0;
        hit   = 1'b0;
        if (par) begin
            kind = ECC_FIX;
            if (syn == '0) begin
                loc = LOC_W'(OVP_WIRE);
            end else if ($onehot(syn)) begin
                for (int p = 0; p < HAM_W; p++) begin
                    if (syn[p]) loc = LOC_W'(CHK_BASE + p);
                end
            end else begin
                for (int i = 0; i < INFO_W; i++) begin
                    if (POS[i] == syn) begin
                        hit      = 1'b1;
                        fixed[i] = ~info[i];
                        loc      = (i < DATA_W) ? LOC_W'(i)
                                                : LOC_W'(i - DATA_W + CTRL_BASE);
                    end
                end
                if (!hit) kind = ECC_BAD;
            end
        end else if (syn != '0) begin
            kind = ECC_BAD;
        end
    end

endmodule

// File: rtl/fault_tracker.sv
module fault_tracker
    import link_repair_pkg::*;
#(
    parameter  int KHITS = 2,
    localparam int CW    = $clog2(KHITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  ecc_kind_e         kind,
    input  logic [LOC_W-1:0]  loc,
    output logic              declare,
    output logic [LANE_W-1:0] declare_lane,
    output logic              side_fault
);

    typedef struct packed {
        logic [LOC_W-1:0] last;
        logic [CW-1:0]    hits;
    } hist_t;

    hist_t         h_d, h_q;
    logic [CW-1:0] run;

    always_comb begin
        h_d          = h_q;
        declare      = 1'b0;
        side_fault   = 1'b0;
        declare_lane = loc[LANE_W-1:0];
        run          = '0;
        if (xfer) begin
            unique case (kind)
                ECC_CLEAN: h_d.hits = '0;
                ECC_FIX: begin
                    if (loc >= LOC_W'(CHK_BASE)) begin
                        side_fault = 1'b1;
                        h_d.hits   = '0;
                    end else begin
                        run = ((h_q.hits != '0) && (h_q.last == loc))
                            ? h_q.hits + CW'(1) : CW'(1);
                        if (run == CW'(KHITS)) begin
                            declare  = 1'b1;
                            h_d.hits = '0;
                        end else begin
                            h_d.hits = run;
                        end
                        h_d.last = loc;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

endmodule

// File: rtl/spare_alloc.sv
module spare_alloc
    import link_repair_pkg::*;
#(
    parameter  int NSPARE = 2,
    localparam int SL_W   = $clog2(NSPARE + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     declare,
    input  logic [LANE_W-1:0]        declare_lane,
    input  logic                     side_fault,
    output logic [NSPARE-1:0]        act,
    output logic [NSPARE*LANE_W-1:0] lane,
    output logic [SL_W-1:0]          left,
    output logic                     failed
);

    typedef struct packed {
        spare_st_e [NSPARE-1:0]              st;
        logic      [NSPARE-1:0][LANE_W-1:0]  lane;
        logic                                failed;
    } tbl_t;

    tbl_t t_d, t_q;
    logic grab;

    always_comb begin
        t_d  = t_q;
        grab = 1'b0;
        if (!t_q.failed) begin
            if (side_fault) begin
                t_d.failed = 1'b1;
            end else if (declare) begin
                for (int s = 0; s < NSPARE; s++) begin
                    if (!grab && (t_q.st[s] == SP_FREE)) begin
                        grab        = 1'b1;
                        t_d.st[s]   = SP_ACTIVE;
                        t_d.lane[s] = declare_lane;
                    end
                end
                if (grab) begin
                    for (int s = 0; s < NSPARE; s++) begin
                        if ((t_q.st[s] == SP_ACTIVE) && (t_q.lane[s] == declare_lane)) begin
                            t_d.st[s] = SP_RETIRED;
                        end
                    end
                end else begin
                    t_d.failed = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    for (genvar s = 0; s < NSPARE; s++) begin : g_out
        assign act[s]                    = (t_q.st[s] == SP_ACTIVE);
        assign lane[s*LANE_W +: LANE_W]  = t_q.lane[s];
    end

    always_comb begin
        left = '0;
        for (int s = 0; s < NSPARE; s++) begin
            if (t_q.st[s] == SP_FREE) left = left + SL_W'(1);
        end
    end

    assign failed = t_q.failed;

endmodule

// File: rtl/spare_link_rx.sv
module spare_link_rx
    import link_repair_pkg::*;
#(
    parameter  int NSPARE = 2,
    parameter  int KHITS  = 2,
    localparam int NW     = FUNC_W + NSPARE,
    localparam int SL_W   = $clog2(NSPARE + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [NW-1:0]            in_wires,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_data,
    output logic [CTRL_W-1:0]        out_ctrl,
    output logic                     out_corrected,
    output logic                     out_uncorrectable,
    output logic [NSPARE-1:0]        steer_active,
    output logic [NSPARE*LANE_W-1:0] steer_lane,
    output logic [SL_W-1:0]          spares_left,
    output logic                     link_failed
);

    logic [DATA_W-1:0] lane_data;
    logic [INFO_W-1:0] fixed;
    ecc_kind_e         kind;
    logic [LOC_W-1:0]  loc;
    logic              declare;
    logic [LANE_W-1:0] declare_lane;
    logic              side_fault;
    out_stage_t        o_d, o_q;

    lane_steer #(.NSPARE(NSPARE)) u_steer (
        .wires (in_wires),
        .act   (steer_active),
        .lane  (steer_lane),
        .data  (lane_data)
    );

    secded_locate u_dec (
        .info  ({in_wires[CTRL_BASE +: CTRL_W], lane_data}),
        .chk   (in_wires[CHK_BASE +: CHK_W]),
        .fixed (fixed),
        .kind  (kind),
        .loc   (loc)
    );

    fault_tracker #(.KHITS(KHITS)) u_hist (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer         (in_valid),
        .kind         (kind),
        .loc          (loc),
        .declare      (declare),
        .declare_lane (declare_lane),
        .side_fault   (side_fault)
    );

    spare_alloc #(.NSPARE(NSPARE)) u_alloc (
        .clk          (clk),
        .rst_n        (rst_n),
        .declare      (declare),
        .declare_lane (declare_lane),
        .side_fault   (side_fault),
        .act          (steer_active),
        .lane         (steer_lane),
        .left         (spares_left),
        .failed       (link_failed)
    );

    always_comb begin
        o_d      = o_q;
        o_d.vld  = in_valid;
        o_d.fix  = in_valid && (kind == ECC_FIX);
        o_d.bad  = in_valid && (kind == ECC_BAD);
        if (in_valid) begin
            o_d.data = fixed[DATA_W-1:0];
            o_d.ctrl = fixed[DATA_W +: CTRL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid         = o_q.vld;
    assign out_data          = o_q.data;
    assign out_ctrl          = o_q.ctrl;
    assign out_corrected     = o_q.fix;
    assign out_uncorrectable = o_q.bad;

endmodule

// File: rtl/spare_link_rx_chk.sv
module spare_link_rx_chk #(
    parameter  int NSPARE = 2,
    localparam int SL_W   = $clog2(NSPARE + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic                 out_corrected,
    input logic                 out_uncorrectable,
    input logic [NSPARE-1:0]    steer_active,
    input logic [NSPARE*6-1:0]  steer_lane,
    input logic [SL_W-1:0]      spares_left,
    input logic                 link_failed
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    flag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_corrected || out_uncorrectable) |-> out_valid);

    // R4
    flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_corrected, out_uncorrectable}));

    // R5
    spares_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spares_left <= $past(spares_left));

    // R8
    map_moves_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(steer_active) && $stable(steer_lane)));

    // R9
    failed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_failed |=> link_failed);

    // R9
    map_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_failed |=> ($stable(steer_active) && $stable(steer_lane)));

endmodule

bind spare_link_rx spare_link_rx_chk #(.NSPARE(NSPARE)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .in_valid          (in_valid),
    .out_valid         (out_valid),
    .out_corrected     (out_corrected),
    .out_uncorrectable (out_uncorrectable),
    .steer_active      (steer_active),
    .steer_lane        (steer_lane),
    .spares_left       (spares_left),
    .link_failed       (link_failed)
);

// File: tb/sim_spare_link_rx.sv
module sim_spare_link_rx;

    localparam int NS = 3;
    localparam int NW = 76 + NS;
    localparam int SLW = $clog2(NS + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [NW-1:0]   in_wires = '0;
    logic            out_valid;
    logic [63:0]     out_data;
    logic [3:0]      out_ctrl;
    logic            out_corrected;
    logic            out_uncorrectable;
    logic [NS-1:0]   steer_active;
    logic [NS*6-1:0] steer_lane;
    logic [SLW-1:0]  spares_left;
    logic            link_failed;

    typedef struct {
        logic [63:0] data;
        logic [3:0]  ctrl;
        bit          fix;
        bit          bad;
        string       req;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_e;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   tb_act [NS];
    int   tb_lane [NS];

    spare_link_rx #(.NSPARE(NS), .KHITS(2)) u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_wires (in_wires),
        .out_valid (out_valid), .out_data (out_data), .out_ctrl (out_ctrl),
        .out_corrected (out_corrected), .out_uncorrectable (out_uncorrectable),
        .steer_active (steer_active), .steer_lane (steer_lane),
        .spares_left (spares_left), .link_failed (link_failed)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Codeword built from the layout stated in R2.
    function automatic logic [75:0] encode(input logic [63:0] d, input logic [3:0] c);
        logic [67:0] info;
        logic [6:0]  h;
        logic        ov;
        int          n;
        info = {c, d};
        h = '0;
        n = 0;
        for (int q = 3; q < 128; q++) begin
            if (((q & (q - 1)) != 0) && (n < 68)) begin
                for (int p = 0; p < 7; p++) if (q[p]) h[p] = h[p] ^ info[n];
                n++;
            end
        end
        ov = (^info) ^ (^h);
        return {c, ov, h, d};
    endfunction

    function automatic logic [NW-1:0] fl(input int a);
        logic [NW-1:0] m;
        m = '0;
        m[a] = 1'b1;
        return m;
    endfunction

    task automatic send(input logic [63:0] d, input logic [3:0] c, input logic [NW-1:0] flips,
                        input bit efix, input bit ebad, input string req);
        logic [NW-1:0] w;
        exp_t e;
        w = '0;
        w[75:0] = encode(d, c);
        for (int s = 0; s < NS; s++) if (tb_act[s]) w[76 + s] = d[tb_lane[s]];
        w = w ^ flips;
        in_valid = 1'b1;
        in_wires = w;
        e.data = d; e.ctrl = c; e.fix = efix; e.bad = ebad; e.req = req;
        sbq.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        idle(1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NS; s++) begin tb_act[s] = 1'b0; tb_lane[s] = 0; end
        @(negedge clk);
        check(sbq.size() == 0, "R2", "pending outputs before reset", sbq.size(), 0);
        sbq.delete();
    endtask

    task automatic check_map(input string req, input logic [NS-1:0] eact,
                             input int espare, input bit efail);
        check(steer_active == eact, req, "steer_active", steer_active, eact);
        check(spares_left == SLW'(espare), req, "spares_left", spares_left, espare);
        check(link_failed == efail, req, "link_failed", link_failed, efail);
    endtask

    task automatic check_lane(input string req, input int s, input int elane);
        check(steer_lane[s*6 +: 6] == 6'(elane), req, "steer_lane", steer_lane[s*6 +: 6], elane);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R2", "unexpected out_valid", 1, 0);
            end else begin
                mon_e = sbq.pop_front();
                check(out_corrected == mon_e.fix, mon_e.req, "out_corrected", out_corrected, mon_e.fix);
                check(out_uncorrectable == mon_e.bad, mon_e.req, "out_uncorrectable",
                      out_uncorrectable, mon_e.bad);
                if (!mon_e.bad) begin
                    check(out_data == mon_e.data, mon_e.req, "out_data", out_data, mon_e.data);
                    check(out_ctrl == mon_e.ctrl, mon_e.req, "out_ctrl", out_ctrl, mon_e.ctrl);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin tb_act[s] = 1'b0; tb_lane[s] = 0; end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        check(out_corrected == 1'b0, "R1", "out_corrected", out_corrected, 0);
        check_map("R1", 3'b000, NS, 1'b0);

        // R2 clean words of several shapes
        send(64'h0, 4'h0, '0, 0, 0, "R2");
        send(64'hFFFF_FFFF_FFFF_FFFF, 4'hF, '0, 0, 0, "R2");
        send(64'hA5A5_5A5A_0F0F_F0F0, 4'h9, '0, 0, 0, "R2");
        send(64'h0123_4567_89AB_CDEF, 4'h6, '0, 0, 0, "R2");
        idle(2);

        // R3 isolated single faults on data pins, separated by clean words
        send(64'hDEAD_BEEF_0000_1111, 4'h3, fl(0), 1, 0, "R3");
        send(64'h1, 4'h0, '0, 0, 0, "R3");
        send(64'h8000_0000_0000_0000, 4'hC, fl(63), 1, 0, "R3");
        send(64'h2, 4'h0, '0, 0, 0, "R3");
        send(64'h7777_8888_9999_AAAA, 4'h5, fl(31), 1, 0, "R3");
        send(64'h3, 4'h0, '0, 0, 0, "R3");
        check_map("R3", 3'b000, NS, 1'b0);

        // R6 different wire restarts the count
        send(64'h1111, 4'h1, fl(20), 1, 0, "R6");
        send(64'h2222, 4'h2, fl(21), 1, 0, "R6");
        check_map("R6", 3'b000, NS, 1'b0);
        // R6 clean word restarts the count
        send(64'h3333, 4'h3, '0, 0, 0, "R6");
        send(64'h4444, 4'h4, fl(21), 1, 0, "R6");
        check_map("R6", 3'b000, NS, 1'b0);

        // R5 two hits on lane 20 with idle cycles between: declared, spare 0
        send(64'h5555, 4'h5, '0, 0, 0, "R5");
        send(64'hFFFF_0000_FFFF_0000, 4'hA, fl(20), 1, 0, "R5");
        idle(3);
        send(64'h0000_FFFF_0000_FFFF, 4'h5, fl(20), 1, 0, "R5");
        check_map("R5", 3'b001, NS - 1, 1'b0);
        check_lane("R5", 0, 20);
        tb_act[0] = 1'b1; tb_lane[0] = 20;

        // R4 double error between two hits on lane 7 does not break the run
        send(64'h0F0F_0F0F_0F0F_0F0F, 4'h2, fl(7), 1, 0, "R4");
        send(64'h1234_5678_9ABC_DEF0, 4'h7, fl(3) | fl(40), 0, 1, "R4");
        check_map("R4", 3'b001, NS - 1, 1'b0);
        send(64'hF0F0_F0F0_F0F0_F0F0, 4'hD, fl(7), 1, 0, "R4");
        check_map("R5", 3'b011, NS - 2, 1'b0);
        check_lane("R5", 1, 7);
        tb_act[1] = 1'b1; tb_lane[1] = 7;

        // R7 original pins of remapped lanes are ignored
        send(64'hCAFE_F00D_0000_0080, 4'hB, fl(20) | fl(7), 0, 0, "R7");
        send(64'h0000_0000_0010_0000, 4'h1, fl(20), 0, 0, "R7");

        // R8 lane 20 fails again on spare 0 twice: moves to spare 2, spare 0 retired
        send(64'h0000_0000_0010_0000, 4'h0, fl(76), 1, 0, "R7");
        send(64'hFFFF_FFFF_FFEF_FFFF, 4'hE, fl(76), 1, 0, "R8");
        check_map("R8", 3'b110, 0, 1'b0);
        check_lane("R8", 2, 20);
        check_lane("R8", 1, 7);
        tb_act[0] = 1'b0; tb_act[2] = 1'b1; tb_lane[2] = 20;
        send(64'h0000_0000_0010_0080, 4'h4, fl(76) | fl(20) | fl(7), 0, 0, "R8");

        // R9 declaration with no spare left
        send(64'h0004_0000_0000_0000, 4'h8, fl(50), 1, 0, "R9");
        send(64'h0, 4'h8, fl(50), 1, 0, "R9");
        check_map("R9", 3'b110, 0, 1'b1);
        send(64'h0008_0000_0000_0000, 4'h1, fl(51), 1, 0, "R9");
        send(64'h0, 4'h1, fl(51), 1, 0, "R9");
        idle(2);
        check_map("R9", 3'b110, 0, 1'b1);
        check_lane("R9", 2, 20);

        // R1 again, then R10 check-wire fault
        do_reset();
        check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        check_map("R1", 3'b000, NS, 1'b0);
        send(64'h5A5A_5A5A_5A5A_5A5A, 4'h6, fl(66), 1, 0, "R10");
        check_map("R10", 3'b000, NS, 1'b1);

        // R10 control-wire fault
        do_reset();
        check_map("R1", 3'b000, NS, 1'b0);
        send(64'h0BAD_C0DE_0000_0001, 4'h5, fl(73), 1, 0, "R10");
        check_map("R10", 3'b000, NS, 1'b1);

        // R10 overall parity wire fault
        do_reset();
        send(64'h1357_9BDF_2468_ACE0, 4'hA, fl(71), 1, 0, "R10");
        check_map("R10", 3'b000, NS, 1'b1);

        idle(2);
        check(sbq.size() == 0, "R2", "outputs still pending", sbq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule